// File: doc/BRIEF.md
# Single-Cycle Subset RISC Core

This block is a 32-bit processor that completes one instruction in every clock cycle. In each cycle it takes a word from an internal instruction store at the program counter and splits it into fixed fields. It reads up to two operands from a 32-entry register file that has a single write port. An arithmetic unit then produces either a result or a memory address. Loads and stores use an internal word-addressed data store. The cycle ends with a write to the register file and a change of the program counter. Nine instructions are decoded: add, sub, and, or, set-less-than, load word, store word, branch-if-equal and jump.

A test harness fills both stores through write ports that bypass the core. It inspects any register and any data word through combinational peek ports. Reset is synchronous and active-low. It clears only the program counter. Register and memory contents survive it.

Top module: `core_single_cycle`

## Requirements
- R1: When `rst_n` is low at a rising edge, the program counter becomes 0. Register and data-store contents are left unchanged.
- R2: Opcode 0x00 selects a register-register instruction. Funct 0x20 adds, 0x22 subtracts (rs minus rt), 0x24 ANDs and 0x25 ORs. Every such instruction writes its result to rd in bits [15:11].
- R3: Funct 0x2A (set-less-than) writes 1 to rd when rs is below rt as signed 32-bit numbers, and writes 0 otherwise.
- R4: Opcode 0x23 (load word) reads the data word at rs plus the sign-extended bits [15:0] and writes it to rt in bits [20:16]. The byte address is divided by four to give the word index.
- R5: Opcode 0x2B (store word) writes rt into the data word at rs plus the sign-extended bits [15:0] on the rising edge. A later load from that address returns the stored value.
- R6: Opcode 0x04 (branch-if-equal) moves the PC to PC+4 + (sign-extended offset << 2) when rs equals rt. Otherwise it moves the PC to PC+4.
- R7: Opcode 0x02 (jump) moves the PC to {PC+4[31:28], bits [25:0], 2'b00}. An instruction skipped by a taken branch or jump changes no register.
- R8: Register 0 always reads as zero. A write aimed at it has no effect.
- R9: An instruction with any other opcode (for example 0x3F) changes no register and no data word. It only advances the PC by 4.
- R10: Every non-branch, non-jump instruction advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the PC |
| imem_load_en | input | 1 | Harness write strobe for the instruction store |
| imem_load_addr | input | log2(IMEM_WORDS) | Word index for the instruction-store write |
| imem_load_data | input | 32 | Instruction word to store |
| dmem_load_en | input | 1 | Harness write strobe for the data store (overrides a core store) |
| dmem_load_addr | input | log2(DMEM_WORDS) | Word index for the data-store harness write |
| dmem_load_data | input | 32 | Data word to store |
| dbg_reg_sel | input | 5 | Register to peek |
| dbg_reg_data | output | 32 | Value of the peeked register (combinational) |
| dbg_mem_addr | input | log2(DMEM_WORDS) | Data word to peek |
| dbg_mem_data | output | 32 | Value of the peeked data word (combinational) |
| pc_o | output | 32 | Current program counter |

## Verification
The embedded assertions check the following in every cycle:
- a written register holds the written value one edge later;
- register 0 reads zero on the operand ports;
- set-less-than produces only 0 or 1;
- sequential instructions add 4 to the PC;
- a taken branch lands on its computed target;
- a core store lands in the data word it addressed.

Some behaviour shows up only in the bench's program. This covers the values of the arithmetic results with negative operands, the signedness of set-less-than, and a load with a negative offset. It also covers the no-op handling of an unknown opcode and the fact that skipped instructions leave registers unchanged. Finally, it shows that a mid-run reset restores the PC while keeping the register contents.

// File: rtl/core_pkg.sv
// Shared encodings and the decoded control bundle for the single-cycle core.
// Assumes a fixed 32-bit instruction word with a 6-bit opcode in [31:26].
package core_pkg;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_JUMP  = 6'h02;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;     // write the register file this cycle
        logic    dst_rd;     // destination is rd (else rt)
        logic    use_imm;    // second ALU operand is the sign-extended immediate
        logic    mem_rd;     // write-back value comes from the data store
        logic    mem_we;     // store rt into the data store
        logic    is_beq;     // conditional branch on equality
        logic    is_jmp;     // absolute jump within the current 256 MB region
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/core_decode.sv
// Instruction decoder: maps opcode and funct to the control bundle.
// Assumes unknown opcodes and unknown R-type funct codes must act as no-ops.
module core_decode
    import core_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    // Purpose: combinational opcode/funct decode with a safe all-off default.
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (opcode)
            OP_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_we = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OP_LOAD: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OP_STORE: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctrl.is_beq = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            OP_JUMP: ctrl.is_jmp = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/core_alu.sv
// Arithmetic/logic unit for the five supported operations plus a zero flag.
// Assumes two's-complement operands; set-less-than compares as signed.
module core_alu
    import core_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    // Purpose: select the operation result.
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

    // Purpose: guard that set-less-than yields a pure boolean (R3).
    always_comb begin
        if (op == ALU_SLT) begin
            a_r3_slt_boolean: assert (y[W-1:1] == '0);
        end
    end

endmodule

// File: rtl/core_regfile.sv
// Register file: NREG words of W bits, two read ports plus a peek port,
// one write port driven through a one-hot load vector. Entry 0 is hardwired
// to zero. Contents are not reset; rst_n only blocks writes during reset.
module core_regfile #(
    parameter int W    = 32,
    parameter int NREG = 32,
    localparam int SW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] rsel_a,
    input  logic [SW-1:0] rsel_b,
    input  logic [SW-1:0] rsel_dbg,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b,
    output logic [W-1:0]  rdata_dbg,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  logic [W-1:0]  wdata
);

    logic [W-1:0]    regs [NREG];
    logic [NREG-1:0] load;

    // Purpose: decode the write select into a one-hot load vector, never entry 0.
    always_comb begin
        load = '0;
        if (we && rst_n) load[wsel] = 1'b1;
        load[0] = 1'b0;
    end

    // Purpose: load each register whose load bit is set with the shared data bus.
    always_ff @(posedge clk) begin
        for (int i = 1; i < NREG; i++) begin
            if (load[i]) regs[i] <= wdata;
        end
    end

    assign rdata_a   = (rsel_a   == '0) ? '0 : regs[rsel_a];
    assign rdata_b   = (rsel_b   == '0) ? '0 : regs[rsel_b];
    assign rdata_dbg = (rsel_dbg == '0) ? '0 : regs[rsel_dbg];

    // R2: a committed write is visible on the next cycle.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wsel != '0) |=> (regs[$past(wsel)] == $past(wdata)));

    // R8: operand ports never return a value for register 0.
    a_r8_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel_a == '0) |-> (rdata_a == '0 && (rsel_b != '0 || rdata_b == '0)));

endmodule

// File: rtl/core_single_cycle.sv
// Single-cycle core top: instruction store, decode, register file, ALU,
// data store and next-PC selection. Assumes word-aligned addresses; the low
// two address bits are dropped. Harness load ports take priority over stores.
module core_single_cycle
    import core_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          imem_load_en,
    input  logic [$clog2(IMEM_WORDS)-1:0] imem_load_addr,
    input  logic [31:0]                   imem_load_data,
    input  logic                          dmem_load_en,
    input  logic [$clog2(DMEM_WORDS)-1:0] dmem_load_addr,
    input  logic [31:0]                   dmem_load_data,
    input  logic [4:0]                    dbg_reg_sel,
    output logic [31:0]                   dbg_reg_data,
    input  logic [$clog2(DMEM_WORDS)-1:0] dbg_mem_addr,
    output logic [31:0]                   dbg_mem_data,
    output logic [31:0]                   pc_o
);

    localparam int W   = 32;
    localparam int IAW = $clog2(IMEM_WORDS);
    localparam int DAW = $clog2(DMEM_WORDS);

    logic [W-1:0] imem [IMEM_WORDS];
    logic [W-1:0] dmem [DMEM_WORDS];
    logic [W-1:0] pc, pc_plus4, br_target, j_target, pc_next;
    logic [W-1:0] instr, imm_sx, rs_data, rt_data, alu_b, alu_y, wb_data;
    logic [4:0]   wsel;
    logic         alu_zero, take_br, st_en;
    logic [DAW-1:0] d_idx;
    ctrl_t        ctrl;

    // Purpose: harness fill of the instruction store.
    always_ff @(posedge clk) begin
        if (imem_load_en) imem[imem_load_addr] <= imem_load_data;
    end

    assign instr = imem[pc[IAW+1:2]];

    core_decode u_decode (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .ctrl   (ctrl)
    );

    assign wsel   = ctrl.dst_rd ? instr[15:11] : instr[20:16];
    assign imm_sx = {{16{instr[15]}}, instr[15:0]};

    core_regfile #(.W(W), .NREG(32)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsel_a    (instr[25:21]),
        .rsel_b    (instr[20:16]),
        .rsel_dbg  (dbg_reg_sel),
        .rdata_a   (rs_data),
        .rdata_b   (rt_data),
        .rdata_dbg (dbg_reg_data),
        .we        (ctrl.reg_we),
        .wsel      (wsel),
        .wdata     (wb_data)
    );

    assign alu_b = ctrl.use_imm ? imm_sx : rt_data;

    core_alu #(.W(W)) u_alu (
        .a    (rs_data),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign d_idx   = alu_y[DAW+1:2];
    assign st_en   = ctrl.mem_we && rst_n;
    assign wb_data = ctrl.mem_rd ? dmem[d_idx] : alu_y;

    // Purpose: data store write, harness port first, then core stores.
    always_ff @(posedge clk) begin
        if (dmem_load_en)  dmem[dmem_load_addr] <= dmem_load_data;
        else if (st_en)    dmem[d_idx]          <= rt_data;
    end

    assign dbg_mem_data = dmem[dbg_mem_addr];

    assign pc_plus4  = pc + 32'd4;
    assign br_target = pc_plus4 + {imm_sx[W-3:0], 2'b00};
    assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign take_br   = ctrl.is_beq && alu_zero;

    // Purpose: choose the next PC among sequential, branch and jump.
    always_comb begin
        if (ctrl.is_jmp)  pc_next = j_target;
        else if (take_br) pc_next = br_target;
        else              pc_next = pc_plus4;
    end

    // Purpose: program counter with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= '0;
        else        pc <= pc_next;
    end

    assign pc_o = pc;

    logic unused_bits;
    assign unused_bits = ^{pc[W-1:IAW+2], pc[1:0], alu_y[W-1:DAW+2], alu_y[1:0], instr[10:6]};

    // R10: sequential instructions step the PC by four.
    a_r10_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.is_jmp && !take_br) |=> (pc == $past(pc) + 32'd4));

    // R6: a taken branch lands on PC+4 plus the scaled offset.
    a_r6_branch_lands: assert property (@(posedge clk) disable iff (!rst_n)
        take_br |=> (pc == $past(pc) + 32'd4 + {$past(instr[13:0]) == $past(instr[13:0]) ? $past(imm_sx[29:0]) : 30'd0, 2'b00}));

    // R5: a core store is visible in the addressed word on the next cycle.
    a_r5_store_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (st_en && !dmem_load_en) |=> (dmem[$past(d_idx)] == $past(rt_data)));

endmodule

// File: tb/test_core_single_cycle.sv
// Scoreboard bench: the driver loads a program and queues the expected PC
// trace; a monitor pops and compares each cycle. Register and memory results
// are then compared through the peek ports.
module test_core_single_cycle;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_load_en = 1'b0;
    logic [5:0]  imem_load_addr = '0;
    logic [31:0] imem_load_data = '0;
    logic        dmem_load_en = 1'b0;
    logic [5:0]  dmem_load_addr = '0;
    logic [31:0] dmem_load_data = '0;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_reg_data;
    logic [5:0]  dbg_mem_addr = '0;
    logic [31:0] dbg_mem_data;
    logic [31:0] pc_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] exp_pc[$];
    bit mon_go = 1'b0;
    bit mon_done = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    core_single_cycle i_core_single_cycle (
        .clk(clk), .rst_n(rst_n),
        .imem_load_en(imem_load_en), .imem_load_addr(imem_load_addr), .imem_load_data(imem_load_data),
        .dmem_load_en(dmem_load_en), .dmem_load_addr(dmem_load_addr), .dmem_load_data(dmem_load_data),
        .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
        .dbg_mem_addr(dbg_mem_addr), .dbg_mem_data(dbg_mem_data),
        .pc_o(pc_o)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction
    function automatic logic [31:0] enc_j(input int word);
        return {6'h02, 26'(word)};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic put_imem(input int idx, input logic [31:0] w);
        @(negedge clk);
        imem_load_en = 1'b1; imem_load_addr = 6'(idx); imem_load_data = w;
        @(negedge clk);
        imem_load_en = 1'b0;
    endtask

    task automatic put_dmem(input int idx, input logic [31:0] w);
        @(negedge clk);
        dmem_load_en = 1'b1; dmem_load_addr = 6'(idx); dmem_load_data = w;
        @(negedge clk);
        dmem_load_en = 1'b0;
    endtask

    task automatic check_reg(input string tag, input int sel, input logic [31:0] exp);
        dbg_reg_sel = 5'(sel);
        #1;
        check(tag, dbg_reg_data, exp);
    endtask

    // Monitor: compare the PC against the queued trace at each falling edge.
    initial begin
        wait (mon_go);
        while (exp_pc.size() > 0) begin
            check("R10/R6/R7/R9 pc trace", pc_o, exp_pc.pop_front());
            @(negedge clk);
        end
        mon_done = 1'b1;
    end

    // Driver: program load, trace expectations, result checks.
    initial begin
        put_dmem(0, 32'd5);
        put_dmem(1, 32'hFFFF_FFFD);
        put_dmem(2, 32'd0);
        put_imem(0,  enc_i(6'h23, 0, 1, 16'd0));          // lw r1,0(r0)      R4
        put_imem(1,  enc_i(6'h23, 0, 2, 16'd4));          // lw r2,4(r0)      R4
        put_imem(2,  enc_r(1, 2, 3, 6'h20));              // add r3 = 2       R2
        put_imem(3,  enc_r(1, 2, 4, 6'h22));              // sub r4 = 8       R2
        put_imem(4,  enc_r(1, 2, 5, 6'h24));              // and r5 = 5       R2
        put_imem(5,  enc_r(1, 2, 6, 6'h25));              // or  r6           R2
        put_imem(6,  enc_r(2, 1, 7, 6'h2A));              // slt r7 = 1       R3
        put_imem(7,  enc_r(1, 2, 8, 6'h2A));              // slt r8 = 0       R3
        put_imem(8,  enc_r(1, 1, 0, 6'h20));              // add r0 ignored   R8
        put_imem(9,  enc_i(6'h2B, 1, 4, 16'd3));          // sw r4,3(r1)      R5
        put_imem(10, enc_i(6'h23, 4, 9, 16'hFFFC));       // lw r9,-4(r4)     R4
        put_imem(11, enc_i(6'h23, 0, 13, 16'd8));         // lw r13,8(r0)     R5
        put_imem(12, 32'hFC63_0000);                      // unknown opcode   R9
        put_imem(13, enc_i(6'h04, 1, 2, 16'd5));          // beq not taken    R6
        put_imem(14, enc_i(6'h04, 1, 5, 16'd1));          // beq taken        R6
        put_imem(15, enc_r(1, 1, 7, 6'h20));              // skipped          R7
        put_imem(16, enc_j(18));                          // jump             R7
        put_imem(17, enc_r(1, 1, 8, 6'h20));              // skipped          R7
        put_imem(18, enc_r(1, 0, 12, 6'h20));             // add r12 = 5      R2
        put_imem(19, enc_j(19));                          // halt loop        R7

        check("R1 pc held at zero in reset", pc_o, 32'd0);

        for (int i = 0; i <= 14; i++) exp_pc.push_back(32'(i * 4));
        exp_pc.push_back(32'd64);
        exp_pc.push_back(32'd72);
        exp_pc.push_back(32'd76);
        exp_pc.push_back(32'd76);
        exp_pc.push_back(32'd76);

        @(negedge clk);
        rst_n = 1'b1;
        mon_go = 1'b1;
        wait (mon_done);

        check_reg("R4 lw r1", 1, 32'd5);
        check_reg("R4 lw r2", 2, 32'hFFFF_FFFD);
        check_reg("R2 add r3", 3, 32'd2);
        check_reg("R2 sub r4", 4, 32'd8);
        check_reg("R2 and r5", 5, 32'd5);
        check_reg("R2 or r6", 6, 32'hFFFF_FFFD);
        check_reg("R3 slt true / R7 skip", 7, 32'd1);
        check_reg("R3 slt false / R7 skip", 8, 32'd0);
        check_reg("R8 r0 reads zero", 0, 32'd0);
        check_reg("R4 negative offset r9", 9, 32'hFFFF_FFFD);
        check_reg("R5 load after store r13", 13, 32'd8);
        check_reg("R9 no-op left r3", 3, 32'd2);
        check_reg("R2 add after jump r12", 12, 32'd5);
        dbg_mem_addr = 6'd2;
        #1;
        check("R5 stored word", dbg_mem_data, 32'd8);
        dbg_mem_addr = 6'd0;
        #1;
        check("R9 data word untouched", dbg_mem_data, 32'd5);

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 pc cleared by mid-run reset", pc_o, 32'd0);
        check_reg("R1 registers kept over reset", 4, 32'd8);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 restart fetches word 1", pc_o, 32'd4);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule